// File: doc/BRIEF.md
# Learning DRAM Command Selector

This block chooses which DRAM command a memory controller issues in each scheduling cycle. The choice is not fixed in logic. An on-chip table keeps a running estimate of long-term value for each pair of system state and command, and the block picks the legal command with the best estimate. After every decision it adjusts the entry of the previous decision toward the reward that decision earned plus the discounted value of the new decision. A command that moves data earns a reward; any other command earns none.

The surrounding controller supplies two things each cycle. The first is a mask of the commands that its timing logic allows right now. The second is six occupancy counts: reads, writes and load misses queued; writes pending to the referenced row; reorder-buffer heads waiting on that row; and the relative age of the request. Each count is reduced to a 2-bit bucket. The six buckets are concatenated and folded by XOR into a table index. A free-running LFSR lets the block sometimes take a random legal command, at a rate set from outside, so that it keeps exploring.

Command codes are 0 open-row (activate), 1 write, 2 read for a load miss, 3 read for a store miss, 4 close of a row that still has pending requests, 5 speculative close, and 6 idle (NOP).

Top module: `rlsched_top`

## Requirements
- R1: After reset `cmd_vld_o` is 0 and `cmd_o` is 6. Every table value starts at zero, so a first decision with several legal commands picks the lowest code.
- R2: A cycle with `step_i` high produces a command on `cmd_o` with `cmd_vld_o` high one clock later. A cycle with `step_i` low gives `cmd_vld_o` low one clock later, and `cmd_o` holds its value.
- R3: Bit i of `legal_i` (i = 0..5) allows command code i. Code 6 is always allowed. The issued code is always an allowed one and is never 7.
- R4: When `explore_rate_i` is 0, the issued command is the allowed command with the highest table value. Ties go to the lowest code.
- R5: The reward is +1.0 (256 in Q8 fixed point) for the decision just taken if it was code 1, 2 or 3. For every other code the reward is 0.
- R6: On each step after the first, the entry Q(s,a) of the previous decision becomes Q + (r + Q(s',a')·2^-GAMMA_SH − Q)·2^-ALPHA_SH, saturated to 16 signed bits. Here (s',a') is the decision of the current step. An unrewarded command therefore gains value when it leads to a command that has value.
- R7: Each count is bucketed as 0→0, 1→1, 2..3→2, ≥4→3. Counts in the same bucket select the same table row. Counts in different buckets of the read count select different rows.
- R8: Each step, a random allowed command replaces the greedy one when the LFSR low byte is below `explore_rate_i`. A rate of 255 therefore makes non-greedy commands appear.
- R9: With `legal_i` all zero the issued command is 6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| step_i | input | 1 | Scheduling cycle: take a decision and learn |
| legal_i | input | 6 | Allowed commands, bit i = code i |
| rd_cnt_i | input | CNT_W | Reads in the transaction queue |
| wr_cnt_i | input | CNT_W | Writes in the transaction queue |
| ldm_cnt_i | input | CNT_W | Load misses in the transaction queue |
| pwr_cnt_i | input | CNT_W | Writes pending to the referenced row |
| robh_cnt_i | input | CNT_W | Reorder-buffer heads waiting on the referenced row |
| rord_i | input | CNT_W | Relative reorder-buffer age of the request |
| explore_rate_i | input | 8 | Exploration probability in 1/256 units |
| cmd_o | output | 3 | Issued command code |
| cmd_vld_o | output | 1 | `cmd_o` carries a new decision |

## Verification
The bench builds the block with its defaults: an 8-bit folded index (256 rows), 16-bit values with 8 fraction bits, learning-rate shift 2 and discount shift 1. With these shifts a rewarded command reaches 64 after one update. An unrewarded command one step ahead of it then gets a nonzero share, so six forced steps are enough to turn a tie into a clear preference, and a discount-only gain can be seen in a single decision. The test states differ only in one count each. They fold to distinct rows, and the read-count buckets 2 and 3 share a row while 4 does not, so bucketing and isolation show up in which command wins.

// File: rtl/rlsched_pkg.sv
package rlsched_pkg;
  localparam int NACT  = 7;
  localparam int AW    = 3;
  localparam int NLEG  = 6;
  localparam int NATTR = 6;
  localparam int LFSR_W = 16;

  typedef enum logic [AW-1:0] {
    C_OPEN     = 3'd0,
    C_WRITE    = 3'd1,
    C_RD_LOAD  = 3'd2,
    C_RD_STORE = 3'd3,
    C_CLOSE_BUSY = 3'd4,
    C_CLOSE_SPEC = 3'd5,
    C_IDLE     = 3'd6
  } cmd_e;

  function automatic logic moves_data(logic [AW-1:0] c);
    return (c == C_WRITE) || (c == C_RD_LOAD) || (c == C_RD_STORE);
  endfunction
endpackage

// File: rtl/rlsched_state_enc.sv
module rlsched_state_enc #(
  parameter int CNT_W = 6,
  parameter int IDX_W = 8
) (
  input  logic [rlsched_pkg::NATTR-1:0][CNT_W-1:0] cnt_i,
  output logic [IDX_W-1:0]                         idx_o
);
  localparam int CAT_W  = 2 * rlsched_pkg::NATTR;
  localparam int CHUNKS = (CAT_W + IDX_W - 1) / IDX_W;
  localparam int PAD_W  = CHUNKS * IDX_W;

  logic [CAT_W-1:0] cat;
  logic [PAD_W-1:0] padded;

  for (genvar g = 0; g < rlsched_pkg::NATTR; g++) begin : g_bucket
    always_comb begin
      if (cnt_i[g] == '0)                   cat[2*g +: 2] = 2'd0;
      else if (cnt_i[g] == CNT_W'(1))       cat[2*g +: 2] = 2'd1;
      else if (cnt_i[g] < CNT_W'(4))        cat[2*g +: 2] = 2'd2;
      else                                  cat[2*g +: 2] = 2'd3;
    end
  end

  assign padded = PAD_W'(cat);

  always_comb begin
    idx_o = '0;
    for (int c = 0; c < CHUNKS; c++) idx_o = idx_o ^ padded[c*IDX_W +: IDX_W];
  end
endmodule

// File: rtl/rlsched_lfsr.sv
module rlsched_lfsr #(
  parameter logic [15:0] SEED = 16'hACE1
) (
  input  logic        clk,
  input  logic        rst_n,
  output logic [15:0] state_o
);
  logic [15:0] lfsr_q, lfsr_d;

  always_comb lfsr_d = {lfsr_q[14:0], lfsr_q[15] ^ lfsr_q[13] ^ lfsr_q[12] ^ lfsr_q[10]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lfsr_q <= SEED;
    else        lfsr_q <= lfsr_d;
  end

  assign state_o = lfsr_q;
endmodule

// File: rtl/rlsched_qtable.sv
module rlsched_qtable #(
  parameter int IDX_W = 8,
  parameter int QW    = 16,
  parameter int NACT  = 7,
  parameter int AW    = 3
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [IDX_W-1:0]          rd_idx_i,
  output logic [NACT-1:0][QW-1:0]   rd_row_o,
  input  logic [IDX_W-1:0]          wr_idx_i,
  output logic [NACT-1:0][QW-1:0]   old_row_o,
  input  logic                      we_i,
  input  logic [AW-1:0]             wact_i,
  input  logic [QW-1:0]             wdata_i
);
  localparam int STATES = 1 << IDX_W;

  for (genvar a = 0; a < NACT; a++) begin : g_col
    logic [QW-1:0] mem [STATES];
    logic          col_en;

    assign col_en = we_i && (wact_i == AW'(a));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        for (int s = 0; s < STATES; s++) mem[s] <= '0;
      end else if (col_en) begin
        mem[wr_idx_i] <= wdata_i;
      end
    end

    assign rd_row_o[a]  = mem[rd_idx_i];
    assign old_row_o[a] = mem[wr_idx_i];
  end
endmodule

// File: rtl/rlsched_pick.sv
module rlsched_pick #(
  parameter int QW   = 16,
  parameter int NACT = 7,
  parameter int AW   = 3
) (
  input  logic [NACT-1:0][QW-1:0] row_i,
  input  logic [NACT-1:0]         legal_i,
  input  logic                    explore_i,
  input  logic [AW-1:0]           start_i,
  output logic [AW-1:0]           act_o
);
  logic [AW-1:0]        best_a, rnd_a, p;
  logic signed [QW-1:0] best_q, cand_q;
  logic                 have_best, have_rnd;

  always_comb begin
    best_a    = AW'(NACT-1);
    best_q    = '0;
    have_best = 1'b0;
    cand_q    = '0;
    for (int i = 0; i < NACT; i++) begin
      cand_q = row_i[i];
      if (legal_i[i] && (!have_best || cand_q > best_q)) begin
        have_best = 1'b1;
        best_q    = cand_q;
        best_a    = AW'(i);
      end
    end
  end

  always_comb begin
    p        = (int'(start_i) >= NACT) ? '0 : start_i;
    rnd_a    = AW'(NACT-1);
    have_rnd = 1'b0;
    for (int k = 0; k < NACT; k++) begin
      int c;
      c = int'(p) + k;
      if (c >= NACT) c = c - NACT;
      if (!have_rnd && legal_i[c]) begin
        have_rnd = 1'b1;
        rnd_a    = AW'(c);
      end
    end
  end

  assign act_o = explore_i ? rnd_a : best_a;
endmodule

// File: rtl/rlsched_top.sv
module rlsched_top #(
  parameter int CNT_W    = 6,
  parameter int IDX_W    = 8,
  parameter int QW       = 16,
  parameter int FRAC     = 8,
  parameter int ALPHA_SH = 2,
  parameter int GAMMA_SH = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step_i,
  input  logic [5:0]       legal_i,
  input  logic [CNT_W-1:0] rd_cnt_i,
  input  logic [CNT_W-1:0] wr_cnt_i,
  input  logic [CNT_W-1:0] ldm_cnt_i,
  input  logic [CNT_W-1:0] pwr_cnt_i,
  input  logic [CNT_W-1:0] robh_cnt_i,
  input  logic [CNT_W-1:0] rord_i,
  input  logic [7:0]       explore_rate_i,
  output logic [2:0]       cmd_o,
  output logic             cmd_vld_o
);
  import rlsched_pkg::*;

  localparam int EW = QW + 3;
  localparam logic signed [EW-1:0] REWARD = EW'(1) <<< FRAC;
  localparam logic signed [EW-1:0] QMAX   = EW'((1 << (QW-1)) - 1);
  localparam logic signed [EW-1:0] QMIN   = ~QMAX;

  logic [1:0] rsync_q;
  logic       rst_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_ok = rsync_q[1];

  logic [NATTR-1:0][CNT_W-1:0] cnts;
  logic [IDX_W-1:0]            cur_idx;
  logic [NACT-1:0][QW-1:0]     cur_row, old_row;
  logic [NACT-1:0]             legal_all;
  logic [LFSR_W-1:0]           lfsr;
  logic                        explore;
  logic [AW-1:0]               pick;

  assign cnts      = {rd_cnt_i, wr_cnt_i, ldm_cnt_i, pwr_cnt_i, robh_cnt_i, rord_i};
  assign legal_all = {1'b1, legal_i};

  rlsched_state_enc #(.CNT_W(CNT_W), .IDX_W(IDX_W)) u_enc (
    .cnt_i(cnts), .idx_o(cur_idx));

  rlsched_lfsr #(.SEED(16'hACE1)) u_lfsr (
    .clk(clk), .rst_n(rst_ok), .state_o(lfsr));

  assign explore = lfsr[7:0] < explore_rate_i;

  rlsched_pick #(.QW(QW), .NACT(NACT), .AW(AW)) u_pick (
    .row_i(cur_row), .legal_i(legal_all), .explore_i(explore),
    .start_i(lfsr[10:8]), .act_o(pick));

  // previous decision, kept for the one-step update
  logic             have_prev_q, have_prev_d;
  logic [IDX_W-1:0] prev_idx_q,  prev_idx_d;
  logic [AW-1:0]    prev_act_q,  prev_act_d;
  logic             prev_rew_q,  prev_rew_d;
  logic [AW-1:0]    cmd_q,       cmd_d;
  logic             vld_q,       vld_d;

  logic                 upd_en;
  logic signed [QW-1:0] q_old, q_next;
  logic signed [EW-1:0] q_old_e, q_next_e, rew_e, td, sum_e, sat_e;
  logic [QW-1:0]        wdata;

  rlsched_qtable #(.IDX_W(IDX_W), .QW(QW), .NACT(NACT), .AW(AW)) u_tab (
    .clk(clk), .rst_n(rst_ok),
    .rd_idx_i(cur_idx), .rd_row_o(cur_row),
    .wr_idx_i(prev_idx_q), .old_row_o(old_row),
    .we_i(upd_en), .wact_i(prev_act_q), .wdata_i(wdata));

  always_comb begin
    upd_en   = step_i && have_prev_q;
    q_old    = old_row[prev_act_q];
    q_next   = cur_row[pick];
    q_old_e  = {{(EW-QW){q_old[QW-1]}}, q_old};
    q_next_e = {{(EW-QW){q_next[QW-1]}}, q_next};
    rew_e    = prev_rew_q ? REWARD : '0;
    td       = rew_e + (q_next_e >>> GAMMA_SH) - q_old_e;
    sum_e    = q_old_e + (td >>> ALPHA_SH);
    if (sum_e > QMAX)      sat_e = QMAX;
    else if (sum_e < QMIN) sat_e = QMIN;
    else                   sat_e = sum_e;
    wdata    = sat_e[QW-1:0];
  end

  always_comb begin
    have_prev_d = have_prev_q;
    prev_idx_d  = prev_idx_q;
    prev_act_d  = prev_act_q;
    prev_rew_d  = prev_rew_q;
    cmd_d       = cmd_q;
    vld_d       = 1'b0;
    if (step_i) begin
      have_prev_d = 1'b1;
      prev_idx_d  = cur_idx;
      prev_act_d  = pick;
      prev_rew_d  = moves_data(pick);
      cmd_d       = pick;
      vld_d       = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_ok) begin
    if (!rst_ok) begin
      have_prev_q <= 1'b0;
      prev_idx_q  <= '0;
      prev_act_q  <= C_IDLE;
      prev_rew_q  <= 1'b0;
      cmd_q       <= C_IDLE;
      vld_q       <= 1'b0;
    end else begin
      have_prev_q <= have_prev_d;
      prev_idx_q  <= prev_idx_d;
      prev_act_q  <= prev_act_d;
      prev_rew_q  <= prev_rew_d;
      cmd_q       <= cmd_d;
      vld_q       <= vld_d;
    end
  end

  assign cmd_o     = cmd_q;
  assign cmd_vld_o = vld_q;
endmodule

// File: rtl/rlsched_chk.sv
module rlsched_chk (
  input logic       clk,
  input logic       rst_ok,
  input logic       step_i,
  input logic [5:0] legal_i,
  input logic [2:0] cmd_o,
  input logic       cmd_vld_o
);
  logic [6:0] legal_seen;

  always_ff @(posedge clk) legal_seen <= {1'b1, legal_i};

  p_vld_after_step_r2: assert property (@(posedge clk) disable iff (!rst_ok)
    step_i |=> cmd_vld_o);

  p_idle_holds_r2: assert property (@(posedge clk) disable iff (!rst_ok)
    !step_i |=> (!cmd_vld_o && $stable(cmd_o)));

  p_code_range_r3: assert property (@(posedge clk) disable iff (!rst_ok)
    cmd_vld_o |-> (cmd_o != 3'd7));

  p_cmd_allowed_r3: assert property (@(posedge clk) disable iff (!rst_ok)
    (cmd_vld_o && cmd_o != 3'd7) |-> legal_seen[cmd_o]);

  p_idle_when_none_r9: assert property (@(posedge clk) disable iff (!rst_ok)
    (step_i && legal_i == 6'd0) |=> (cmd_o == 3'd6));
endmodule

bind rlsched_top rlsched_chk u_chk (
  .clk(clk), .rst_ok(rst_ok), .step_i(step_i), .legal_i(legal_i),
  .cmd_o(cmd_o), .cmd_vld_o(cmd_vld_o));

// File: tb/sim_rlsched_top.sv
`timescale 1ns/1ps
module sim_rlsched_top;
  localparam int CNT_W = 6;

  logic clk = 1'b0;
  logic rst_n;
  logic step_i;
  logic [5:0] legal_i;
  logic [CNT_W-1:0] rd_c, wr_c, ld_c, pw_c, rh_c, ro_c;
  logic [7:0] rate;
  logic [2:0] cmd_o;
  logic cmd_vld_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  rlsched_top u0 (
    .clk(clk), .rst_n(rst_n), .step_i(step_i), .legal_i(legal_i),
    .rd_cnt_i(rd_c), .wr_cnt_i(wr_c), .ldm_cnt_i(ld_c), .pwr_cnt_i(pw_c),
    .robh_cnt_i(rh_c), .rord_i(ro_c), .explore_rate_i(rate),
    .cmd_o(cmd_o), .cmd_vld_o(cmd_vld_o));

  // {legal, rd, wr, ld, pw, rh, ro, reps, expected code, requirement, pad}
  function automatic logic [39:0] mk(logic [5:0] lg, logic [2:0] rd, logic [2:0] wr,
                                     logic [2:0] ld, logic [2:0] pw, logic [2:0] rh,
                                     logic [2:0] ro, logic [2:0] reps, logic [2:0] ex,
                                     logic [3:0] rq);
    return {lg, rd, wr, ld, pw, rh, ro, reps, ex, rq, 6'd0};
  endfunction

  localparam int NV = 13;
  localparam logic [39:0] VEC [NV] = '{
    mk(6'h3F, 0,0,1,0,0,0, 1, 0, 1),  // R1: zero table, tie goes to code 0
    mk(6'h04, 0,0,0,0,0,0, 6, 2, 3),  // R3: only load read allowed
    mk(6'h05, 0,0,0,0,0,0, 2, 2, 5),  // R5: read earned value over open-row
    mk(6'h02, 1,0,0,0,0,0, 6, 1, 3),  // R3: only write allowed
    mk(6'h03, 1,0,0,0,0,0, 2, 1, 5),  // R5: write earned value
    mk(6'h10, 0,0,0,0,0,1, 6, 4, 3),  // R3: only busy close allowed
    mk(6'h11, 0,0,0,0,0,1, 2, 0, 5),  // R5: close earned nothing, tie to code 0
    mk(6'h08, 2,0,0,0,0,0, 6, 3, 3),  // R3: only store read, read count 2
    mk(6'h09, 3,0,0,0,0,0, 1, 3, 7),  // R7: count 3 shares bucket with 2
    mk(6'h09, 4,0,0,0,0,0, 1, 0, 7),  // R7: count 4 is a fresh bucket
    mk(6'h00, 0,0,0,0,0,0, 1, 6, 9),  // R9: nothing allowed gives idle
    mk(6'h3F, 0,0,0,0,0,0, 1, 2, 4),  // R4: greedy choice among all
    mk(6'h20, 0,0,0,0,0,0, 1, 6, 6)   // R6: idle gained discounted value
  };

  task automatic check(input bit ok, input int rq, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL R%0d %s: actual %0d expected %0d", rq, what, act, exp);
    end
  endtask

  task automatic set_state(input logic [39:0] v);
    legal_i = v[39:34];
    rd_c = CNT_W'(v[33:31]); wr_c = CNT_W'(v[30:28]); ld_c = CNT_W'(v[27:25]);
    pw_c = CNT_W'(v[24:22]); rh_c = CNT_W'(v[21:19]); ro_c = CNT_W'(v[18:16]);
  endtask

  task automatic do_step();
    step_i = 1'b1;
    @(negedge clk);
    step_i = 1'b0;
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL R2 watchdog: actual %0d expected %0d", 0, 1);
      summary();
      $finish;
    end
  end

  initial begin
    int nongreedy;
    rst_n = 1'b0; step_i = 1'b0; rate = 8'd0;
    set_state(mk(6'h00, 0,0,0,0,0,0, 0, 0, 0));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1: reset state
    check(cmd_vld_o == 1'b0, 1, "valid after reset", cmd_vld_o, 0);
    check(cmd_o == 3'd6, 1, "command after reset", cmd_o, 6);

    for (int i = 0; i < NV; i++) begin
      set_state(VEC[i]);
      for (int r = 0; r < int'(VEC[i][15:13]); r++) begin
        do_step();
        check(cmd_vld_o == 1'b1, 2, "valid after step", cmd_vld_o, 1);
        check(cmd_o == VEC[i][12:10], int'(VEC[i][9:6]), "vector command",
              cmd_o, int'(VEC[i][12:10]));
      end
    end

    // R2: idle cycle keeps command, drops valid
    @(negedge clk);
    check(cmd_vld_o == 1'b0, 2, "valid without step", cmd_vld_o, 0);
    check(cmd_o == 3'd6, 2, "held command", cmd_o, 6);

    // R8: exploration at full rate, allowed set {0,2,5} plus idle
    rate = 8'd255;
    set_state(mk(6'h25, 0,0,0,0,0,0, 0, 0, 0));
    nongreedy = 0;
    for (int s = 0; s < 40; s++) begin
      do_step();
      check(cmd_o == 3'd0 || cmd_o == 3'd2 || cmd_o == 3'd5 || cmd_o == 3'd6,
            3, "explored command allowed", cmd_o, 2);
      if (cmd_o != 3'd2) nongreedy++;
    end
    check(nongreedy > 0, 8, "non-greedy picks seen", nongreedy, 1);
    rate = 8'd0;

    done = 1'b1;
    summary();
    $finish;
  end
endmodule